// File: doc/BRIEF.md
# Cache RAM Latency Control Register

This block holds the wait-state settings that the timing logic of an L2 cache RAM uses for its data, tag and way-select arrays. Software writes new settings through a 32-bit register port. A plain write changes only a shadow copy. The settings drive the cache RAM only after software raises an apply request in the same write.

When an apply request arrives, the lock flag drops and a settling counter starts. When the counter expires, the shadow settings move into the active outputs and the lock flag rises again. Software polls the lock flag to learn that the new timing is in effect. The settling time is the parameter `SETTLE_CYC`, which defaults to 16 cycles. Read data is combinational and is valid in the same cycle as the read request.

Top module: `l2_lat_ctrl`

## Requirements
- R1: After reset all three latency outputs are 0, and the register reads 0x8000_0000: the lock flag is 1, the apply bit is 0 and every field is 0.
- R2: The register answers at byte offset 0x28. Bits 1:0 hold the data latency, bits 3:2 the tag latency and bits 5:4 the way-select latency. Bit 13 is the apply bit and bit 31 is the lock flag. All other bits read 0, and a read of any other offset returns 0.
- R3: A write with bit 13 clear updates the readable fields only. The latency outputs and the lock flag keep their values.
- R4: In the cycle after a write with bit 13 set, the register reads lock 0 and apply 1.
- R5: Exactly `SETTLE_CYC` cycles after the write edge of an apply request, the outputs take the stored fields. In the same cycle the lock flag reads 1 and bit 13 reads 0.
- R6: A write with bit 13 clear during settling changes the stored fields, and the pending apply loads those latest fields.
- R7: An apply request during settling, including in the cycle the count would expire, restarts the full count. The outputs do not change at that edge.
- R8: A write to any other offset, or with the request low, changes neither the fields nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| data_lat_o | output | 2 | Active data RAM latency |
| tag_lat_o | output | 2 | Active tag RAM latency |
| way_lat_o | output | 2 | Active way-select latency |

## Verification
Two functions can fall in the same cycle: a software write and the expiry of the settling count. The bench provokes this by issuing a write exactly `SETTLE_CYC` cycles after an apply request. It does this once with bit 13 clear, where the old stored fields must still be loaded. It does it again with bit 13 set, where the restart must win and leave the outputs unchanged. A behavioural model steps through every clock, and the bench compares the outputs and the read data against that model on every cycle.

// File: rtl/l2_lat_pkg.sv
package l2_lat_pkg;
  localparam int LAT_W     = 2;
  localparam int DW        = 32;
  localparam int DATA_LSB  = 0;
  localparam int TAG_LSB   = 2;
  localparam int WAY_LSB   = 4;
  localparam int APPLY_BIT = 13;
  localparam int LOCK_BIT  = 31;

  typedef struct packed {
    logic [LAT_W-1:0] way;
    logic [LAT_W-1:0] tag;
    logic [LAT_W-1:0] data;
  } lat_cfg_t;
endpackage

// File: rtl/l2_lat_shadow.sv
module l2_lat_shadow
  import l2_lat_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int REG_OFF = 'h28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              busy_i,
  output lat_cfg_t          shadow_o,
  output logic              wr_hit_o,
  output logic              apply_o,
  output logic [DW-1:0]     rdata_o
);
  logic     sel;
  lat_cfg_t shadow_q;

  assign sel      = (addr_i == ADDR_W'(REG_OFF));
  assign wr_hit_o = req_i && we_i && sel;
  assign apply_o  = wr_hit_o && wdata_i[APPLY_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_hit_o) begin
      shadow_q.data <= wdata_i[DATA_LSB +: LAT_W];
      shadow_q.tag  <= wdata_i[TAG_LSB  +: LAT_W];
      shadow_q.way  <= wdata_i[WAY_LSB  +: LAT_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i && sel) begin
      rdata_o[DATA_LSB +: LAT_W] = shadow_q.data;
      rdata_o[TAG_LSB  +: LAT_W] = shadow_q.tag;
      rdata_o[WAY_LSB  +: LAT_W] = shadow_q.way;
      rdata_o[APPLY_BIT]         = busy_i;
      rdata_o[LOCK_BIT]          = !busy_i;
    end
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/l2_lat_seq.sv
module l2_lat_seq #(
  parameter int SETTLE_CYC = 16,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             apply_i,
  output logic             busy_o,
  output logic             load_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // restart has priority over expiry
  assign load_o = busy_q && !apply_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (apply_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(SETTLE_CYC);
    end else if (load_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/l2_lat_active.sv
module l2_lat_active
  import l2_lat_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  lat_cfg_t shadow_i,
  output lat_cfg_t active_o
);
  lat_cfg_t active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '0;
    else if (load_i) active_q <= shadow_i;
  end

  assign active_o = active_q;
endmodule

// File: rtl/l2_lat_ctrl.sv
module l2_lat_ctrl
  import l2_lat_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFF    = 'h28,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [1:0]        data_lat_o,
  output logic [1:0]        tag_lat_o,
  output logic [1:0]        way_lat_o
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);

  lat_cfg_t         shadow, active;
  logic             wr_hit, apply, busy, load;
  logic [CNT_W-1:0] cnt;

  l2_lat_shadow #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) u_shadow (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .busy_i(busy), .shadow_o(shadow), .wr_hit_o(wr_hit),
    .apply_o(apply), .rdata_o(rdata_o)
  );

  l2_lat_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i, .rst_ni, .apply_i(apply),
    .busy_o(busy), .load_o(load), .cnt_o(cnt)
  );

  l2_lat_active u_active (
    .clk_i, .rst_ni, .load_i(load), .shadow_i(shadow), .active_o(active)
  );

  assign data_lat_o = active.data;
  assign tag_lat_o  = active.tag;
  assign way_lat_o  = active.way;
endmodule

// File: rtl/l2_lat_ctrl_chk.sv
module l2_lat_ctrl_chk
  import l2_lat_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter int CNT_W      = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_hit_i,
  input logic             apply_i,
  input logic             busy_i,
  input logic [CNT_W-1:0] cnt_i,
  input lat_cfg_t         shadow_i,
  input lat_cfg_t         active_i
);
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(active_i)); // R3
  AST_APPLY_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply_i |=> busy_i && cnt_i == CNT_W'(SETTLE_CYC)); // R4
  AST_LOAD_ON_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> active_i == $past(shadow_i)); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !apply_i && cnt_i > CNT_W'(1) |=> busy_i && cnt_i == $past(cnt_i) - CNT_W'(1)); // R5
  AST_RESTART_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && apply_i |=> $stable(active_i) && busy_i); // R7
  AST_MISS_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit_i |=> $stable(shadow_i)); // R8
endmodule

bind l2_lat_ctrl l2_lat_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_hit_i(wr_hit), .apply_i(apply),
  .busy_i(busy), .cnt_i(cnt), .shadow_i(shadow), .active_i(active)
);

// File: tb/tb_l2_lat_ctrl.sv
module tb_l2_lat_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int S = 16;
  localparam logic [7:0] OFF = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic [1:0]  data_lat_o, tag_lat_o, way_lat_o;

  always #2.5 clk = ~clk;

  l2_lat_ctrl #(.ADDR_W(8), .REG_OFF('h28), .SETTLE_CYC(S)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_o), .data_lat_o(data_lat_o),
    .tag_lat_o(tag_lat_o), .way_lat_o(way_lat_o)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference: index 0 data, 1 tag, 2 way
  int m_sh[3];
  int m_act[3];
  bit m_busy;
  int m_cnt;

  function automatic logic [31:0] m_word();
    int w;
    w = m_sh[0] + (m_sh[1] << 2) + (m_sh[2] << 4);
    if (m_busy) w = w + (1 << 13);
    else        w = w | 32'h8000_0000;
    return 32'(w);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit rq, bit w, logic [7:0] a, logic [31:0] d);
    logic [31:0] exp_rd;
    bit hit;
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d;
    #1;
    exp_rd = (rq && !w && a == OFF) ? m_word() : 32'h0;
    chk(tag, "rdata", rdata_o, exp_rd);
    chk(tag, "data_lat", 32'(data_lat_o), 32'(m_act[0]));
    chk(tag, "tag_lat",  32'(tag_lat_o),  32'(m_act[1]));
    chk(tag, "way_lat",  32'(way_lat_o),  32'(m_act[2]));
    @(posedge clk);
    hit = rq && w && (a == OFF);
    if (hit && d[13]) begin
      m_busy = 1; m_cnt = S;
    end else if (m_busy) begin
      if (m_cnt == 1) begin
        for (int i = 0; i < 3; i++) m_act[i] = m_sh[i];
        m_busy = 0; m_cnt = 0;
      end else m_cnt--;
    end
    if (hit) begin
      m_sh[0] = int'(d[1:0]); m_sh[1] = int'(d[3:2]); m_sh[2] = int'(d[5:4]);
    end
  endtask

  task automatic rd(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 1, 0, OFF, 32'h0);
  endtask

  task automatic wr(string tag, logic [31:0] d);
    cyc(tag, 1, 1, OFF, d);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin m_sh[i] = 0; m_act[i] = 0; end
    m_busy = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1", "reset rdata", rdata_o, 32'h0);
    rd("R1", 2);
    chk("R1", "reset word", m_word(), 32'h8000_0000);

    // R2 field layout, unused bits read 0, other offset reads 0
    wr("R2", 32'hFFFF_DFFF);
    @(negedge clk); req = 1; we = 0; addr = OFF; #1;
    chk("R2", "layout", rdata_o, 32'h8000_003F);
    cyc("R2", 1, 0, 8'h2C, 32'h0);

    // R3 plain write: shadow only
    wr("R3", 32'h0000_0015);
    rd("R3", 4);
    chk("R3", "outputs held", {26'h0, way_lat_o, tag_lat_o, data_lat_o}, 32'h0);

    // R4 / R5 apply and lock timing
    wr("R4", 32'h0000_2039);
    rd("R4", 1);
    rd("R5", S + 2);
    chk("R5", "data after lock", 32'(data_lat_o), 32'd1);
    chk("R5", "tag after lock",  32'(tag_lat_o),  32'd2);
    chk("R5", "way after lock",  32'(way_lat_o),  32'd3);

    // R8 ignored accesses
    cyc("R8", 1, 1, 8'h2C, 32'h0000_2000);
    cyc("R8", 0, 1, OFF,   32'h0000_2000);
    rd("R8", S + 2);

    // R6 plain write during settling
    wr("R6", 32'h0000_2000);
    rd("R6", 5);
    wr("R6", 32'h0000_0026);
    rd("R6", S);
    chk("R6", "latest fields", {26'h0, way_lat_o, tag_lat_o, data_lat_o}, 32'h26);

    // write exactly at expiry, bit 13 clear: old fields load
    wr("R6", 32'h0000_2011);
    rd("R6", S - 1);
    wr("R6", 32'h0000_0002);
    rd("R6", 3);
    chk("R6", "expiry collision", {26'h0, way_lat_o, tag_lat_o, data_lat_o}, 32'h11);

    // R7 restart mid-way and at expiry
    wr("R7", 32'h0000_2033);
    rd("R7", 7);
    wr("R7", 32'h0000_2022);
    rd("R7", S - 1);
    wr("R7", 32'h0000_203F);
    rd("R7", S - 1);
    chk("R7", "held before expiry", {26'h0, way_lat_o, tag_lat_o, data_lat_o}, 32'h11);
    rd("R7", 2);
    chk("R7", "final", {26'h0, way_lat_o, tag_lat_o, data_lat_o}, 32'h3F);

    @(negedge clk); req = 0; we = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule